// File: doc/BRIEF.md
# Stop-Mode Wake-Up Controller

This block decides when a microcontroller core that has halted in its low-power stop state may resume. Software programs one 8-bit control byte over a simple strobed register bus. The byte picks the wake source, the level that source must reach, and whether a stretched reset follows the wake. It also holds a clock pre-divide choice that the clock tree reads. While the core reports that it is stopped, the chosen source is compared with the programmed level. On a match, the block raises a wake request and then drives a reset pulse into the core.

A wake source can be a single synchronized pin, the NOR of the low nibble of a port, or the NOR of a whole port byte. Two codes never wake the core. One of them leaves the external power-on reset as the only way out of stop. A sticky status bit tells software, after it restarts, whether it came back from stop or from a cold start. Only power-on clears that bit. A wake-up also forces the clock pre-divide back to "undivided".

Top module: `stop_wake_ctrl`

## Requirements
- R1: After `por_n` is released, a read returns 8'h7F, `clk_div16` is 0, and `wake_req` and `core_rst` are 0.
- R2: A read returns the status flag in bit 7 and ones in bits 6:0, whatever was written. Writing bit 7 never changes the flag.
- R3: The source field is written at bits 4:2. Code 2 selects `pin_a[0]`, 3 selects `pin_a[1]`, 4 selects `pin_a[2]`, 5 selects `pin_b[7]`, 6 selects the NOR of `pin_b[3:0]`, and 7 selects the NOR of `pin_b[7:0]`.
- R4: Bit 6 sets the active level. With 0, a low source value wakes the core; with 1, a high value does.
- R5: Source codes 0 and 1 never raise `wake_req`, for any pin values.
- R6: `wake_req` is 0 whenever `stop_in` is 0.
- R7: Pins pass through two flops. A pin change set up before clock edge k shows on `wake_req` after edge k+1 and not after edge k.
- R8: With bit 5 at 0, `core_rst` goes high at the edge after `wake_req` rises and stays high for exactly RST_CYCLES cycles.
- R9: With bit 5 at 1, `core_rst` is high for exactly one cycle, starting at the edge after `wake_req` rises.
- R10: A wake sets the status flag, so bit 7 reads 1. Later writes leave it at 1, and only `por_n` clears it.
- R11: Bits 1:0 hold the pre-divide. `clk_div16` is 1 for codes 2 and 3 and 0 for codes 0 and 1. A wake forces the code to 0 at the same edge that starts `core_rst`.
- R12: One rising edge of `wake_req` produces exactly one `core_rst` pulse, even while the wake condition stays true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| reg_wr | input | 1 | Write strobe for the control byte |
| reg_rd | input | 1 | Read strobe for the control byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while `reg_rd` is high, else 0 |
| stop_in | input | 1 | Core is in stop state |
| pin_a | input | 3 | Single-pin wake sources |
| pin_b | input | 8 | Port byte: one single pin and the NOR sources |
| wake_req | output | 1 | Wake request |
| core_rst | output | 1 | Reset to the core after a wake |
| clk_div16 | output | 1 | Clock pre-divide by 16 selected |

## Verification
A wrong source decode or wrong polarity shows on `wake_req` in the same cycle that `stop_in` rises after the pins have settled. The sweep over every code, both levels and a set of pin patterns catches it at once. Faults in the synchronizer depth or the reset sequencer show up as a shift of one or more cycles in the edge where `wake_req` or `core_rst` changes, or as a wrong pulse length. The bench measures both cycle by cycle. A lost or wrongly set status flag, or a pre-divide that is not cleared, shows at the next register read or on `clk_div16` in the cycle after the wake.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [2:0] {
    SRC_POR_ONLY = 3'd0,
    SRC_NONE     = 3'd1,
    SRC_A0       = 3'd2,
    SRC_A1       = 3'd3,
    SRC_A2       = 3'd4,
    SRC_B7       = 3'd5,
    SRC_NOR_LO   = 3'd6,
    SRC_NOR_ALL  = 3'd7
  } wake_src_e;

  // Control byte layout below the status flag: [6] level, [5] delay skip,
  // [4:2] source, [1:0] pre-divide.
  typedef struct packed {
    logic      level_hi;
    logic      dly_skip;
    wake_src_e src;
    logic [1:0] div;
  } wake_cfg_t;

  localparam wake_cfg_t CFG_DEFAULT = '{
    level_hi: 1'b0,
    dly_skip: 1'b0,
    src:      SRC_POR_ONLY,
    div:      2'b00
  };

  function automatic logic div16_on(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic [7:0] readback(input logic flag);
    return {flag, 7'h7F};
  endfunction

  function automatic wake_cfg_t cfg_from_byte(input logic [6:0] b);
    return wake_cfg_t'(b);
  endfunction

endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d_i;
      s2 <= s1;
    end
  end

  assign q_o = s2;
endmodule

// File: rtl/swc_src_sel.sv
module swc_src_sel
  import swc_pkg::*;
#(
  parameter int PA_W    = 3,
  parameter int PB_W    = 8,
  parameter int PB_LO_W = 4
) (
  input  wake_src_e       src_i,
  input  logic            level_hi_i,
  input  logic [PA_W-1:0] pa_i,
  input  logic [PB_W-1:0] pb_i,
  output logic            valid_o,
  output logic            value_o,
  output logic            match_o
);
  localparam int PB_PIN = PB_W - 1;

  function automatic logic [1:0] pick(input wake_src_e s,
                                      input logic [PA_W-1:0] a,
                                      input logic [PB_W-1:0] b);
    // returns {valid, value}
    case (s)
      SRC_A0:      return {1'b1, a[0]};
      SRC_A1:      return {1'b1, a[1]};
      SRC_A2:      return {1'b1, a[2]};
      SRC_B7:      return {1'b1, b[PB_PIN]};
      SRC_NOR_LO:  return {1'b1, ~|b[PB_LO_W-1:0]};
      SRC_NOR_ALL: return {1'b1, ~|b};
      default:     return 2'b00;
    endcase
  endfunction

  logic [1:0] sel;
  assign sel     = pick(src_i, pa_i, pb_i);
  assign valid_o = sel[1];
  assign value_o = sel[0];
  assign match_o = sel[1] & (sel[0] == level_hi_i);
endmodule

// File: rtl/swc_rst_seq.sv
module swc_rst_seq #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic start_i,
  input  logic skip_i,
  output logic rst_o,
  output logic idle_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LONG_LEN = CW'(RST_CYCLES);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start_i) begin
        busy <= 1'b1;
        cnt  <= skip_i ? ONE : LONG_LEN;
      end
    end else begin
      if (cnt == ONE) busy <= 1'b0;
      cnt <= cnt - ONE;
    end
  end

  assign rst_o  = busy;
  assign idle_o = !busy;
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int RST_CYCLES = 16,
  parameter int PA_W       = 3,
  parameter int PB_W       = 8,
  parameter int PB_LO_W    = 4
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            stop_in,
  input  logic [PA_W-1:0] pin_a,
  input  logic [PB_W-1:0] pin_b,
  output logic            wake_req,
  output logic            core_rst,
  output logic            clk_div16
);
  wake_cfg_t       cfg;
  logic            wake_flag;
  logic            wake_q;
  logic            seq_idle;
  logic            wake_evt;
  logic            src_valid, src_value, src_match;
  logic [PA_W-1:0] pa_s;
  logic [PB_W-1:0] pb_s;
  logic            unused_wdata_msb;

  assign unused_wdata_msb = reg_wdata[7];

  swc_sync #(.W(PA_W)) sync_a_i (.clk(clk), .por_n(por_n), .d_i(pin_a), .q_o(pa_s));
  swc_sync #(.W(PB_W)) sync_b_i (.clk(clk), .por_n(por_n), .d_i(pin_b), .q_o(pb_s));

  swc_src_sel #(.PA_W(PA_W), .PB_W(PB_W), .PB_LO_W(PB_LO_W)) sel_i (
    .src_i(cfg.src), .level_hi_i(cfg.level_hi), .pa_i(pa_s), .pb_i(pb_s),
    .valid_o(src_valid), .value_o(src_value), .match_o(src_match)
  );

  assign wake_req = stop_in & src_match;
  assign wake_evt = wake_req & ~wake_q & seq_idle;

  swc_rst_seq #(.RST_CYCLES(RST_CYCLES)) seq_i (
    .clk(clk), .por_n(por_n), .start_i(wake_evt), .skip_i(cfg.dly_skip),
    .rst_o(core_rst), .idle_o(seq_idle)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg       <= CFG_DEFAULT;
      wake_flag <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      wake_q <= wake_req;
      if (reg_wr) cfg <= cfg_from_byte(reg_wdata[6:0]);
      if (wake_evt) begin
        cfg.div   <= 2'b00;
        wake_flag <= 1'b1;
      end
    end
  end

  assign reg_rdata = reg_rd ? readback(wake_flag) : 8'h00;
  assign clk_div16 = div16_on(cfg.div);
endmodule

// File: rtl/swc_chk.sv
module swc_chk (
  input logic       clk,
  input logic       por_n,
  input logic       stop_in,
  input logic       wake_req,
  input logic       wake_evt,
  input logic       core_rst,
  input logic       clk_div16,
  input logic       wake_flag,
  input logic [2:0] src_code,
  input logic       dly_skip
);
  p_stop_gate_r6: assert property (@(posedge clk) disable iff (!por_n)
    !stop_in |-> !wake_req);

  p_dead_codes_r5: assert property (@(posedge clk) disable iff (!por_n)
    (src_code == 3'd0 || src_code == 3'd1) |-> !wake_req);

  p_rst_follows_r8: assert property (@(posedge clk) disable iff (!por_n)
    wake_evt |=> core_rst);

  p_short_pulse_r9: assert property (@(posedge clk) disable iff (!por_n)
    (wake_evt && dly_skip) |=> core_rst ##1 !core_rst);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
    wake_flag |=> wake_flag);

  p_div_cleared_r11: assert property (@(posedge clk) disable iff (!por_n)
    wake_evt |=> !clk_div16);
endmodule

bind stop_wake_ctrl swc_chk chk_i (
  .clk(clk), .por_n(por_n), .stop_in(stop_in), .wake_req(wake_req),
  .wake_evt(wake_evt), .core_rst(core_rst), .clk_div16(clk_div16),
  .wake_flag(wake_flag), .src_code(cfg.src), .dly_skip(cfg.dly_skip)
);

// File: tb/stop_wake_ctrl_tb.sv
`timescale 1ns/1ps
module stop_wake_ctrl_tb_top;
  localparam int RST_CYCLES = 16;
  localparam real HALF = 2.0;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       stop_in = 1'b0;
  logic [2:0] pin_a = 3'b000;
  logic [7:0] pin_b = 8'h00;
  logic       wake_req, core_rst, clk_div16;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(HALF) clk = ~clk;

  stop_wake_ctrl #(.RST_CYCLES(RST_CYCLES)) dut_i (
    .clk(clk), .por_n(por_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop_in(stop_in),
    .pin_a(pin_a), .pin_b(pin_b), .wake_req(wake_req),
    .core_rst(core_rst), .clk_div16(clk_div16)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    reg_rd = 1'b1; #0.5; d = reg_rdata; reg_rd = 1'b0;
  endtask

  function automatic logic exp_wake(input int src, input logic lvl,
                                    input logic [2:0] a, input logic [7:0] b,
                                    input logic stp);
    logic v, s;
    v = 1'b1;
    case (src)
      2: s = a[0];
      3: s = a[1];
      4: s = a[2];
      5: s = b[7];
      6: s = (b[3:0] == 4'h0);
      7: s = (b == 8'h00);
      default: begin v = 1'b0; s = 1'b0; end
    endcase
    return stp & v & (s == lvl);
  endfunction

  initial begin
    #(2.0 * HALF * 190000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int hi, rises;
    logic prev;
    cyc(3);
    por_n = 1'b1;
    cyc(2);
    // R1 reset state
    rd(d); check("R1 readback", d, 8'h7F);
    check("R1 div", {7'b0, clk_div16}, 8'h00);
    check("R1 wake", {6'b0, wake_req, core_rst}, 8'h00);

    // R7 latency, R9 short pulse, R10 flag, R11 clear
    wr(8'h6A);                       // level 1, skip, src 2, div 2
    check("R11 div16 on", {7'b0, clk_div16}, 8'h01);
    stop_in = 1'b1; cyc(3);
    pin_a = 3'b001;
    @(posedge clk); #1; check("R7 not after first edge", {7'b0, wake_req}, 8'h00);
    @(posedge clk); #1; check("R7 after second edge", {7'b0, wake_req}, 8'h01);
    check("R9 no reset yet", {7'b0, core_rst}, 8'h00);
    @(posedge clk); #1; check("R9 reset high", {7'b0, core_rst}, 8'h01);
    check("R11 div cleared", {7'b0, clk_div16}, 8'h00);
    @(posedge clk); #1; check("R9 one cycle", {7'b0, core_rst}, 8'h00);
    @(negedge clk); rd(d); check("R10 flag set", d, 8'hFF);
    stop_in = 1'b0; pin_a = 3'b000; cyc(3);

    // R2/R10 writes do not clear flag
    wr(8'h00); rd(d); check("R2 write bit7 0", d, 8'hFF);
    wr(8'hFF); rd(d); check("R2 write all ones", d, 8'hFF);

    // R8 long pulse, R12 single pulse
    wr(8'h48);                       // level 1, delay on, src 2
    stop_in = 1'b1; cyc(3);
    pin_a = 3'b001;
    hi = 0; rises = 0; prev = 1'b0;
    for (int i = 0; i < RST_CYCLES + 30; i++) begin
      @(negedge clk);
      if (core_rst) hi++;
      if (core_rst && !prev) rises++;
      prev = core_rst;
    end
    check("R8 pulse length", 8'(hi), 8'(RST_CYCLES));
    check("R12 single pulse", 8'(rises), 8'd1);
    stop_in = 1'b0; pin_a = 3'b000; cyc(3);

    // R11 div codes
    for (int c = 0; c < 4; c++) begin
      wr(8'(c) | 8'h04);
      check("R11 div code", {7'b0, clk_div16}, (c >= 2) ? 8'h01 : 8'h00);
    end

    // R3 R4 R5 R6 sweep
    for (int src = 0; src < 8; src++) begin
      for (int lv = 0; lv < 2; lv++) begin
        wr({1'b0, 1'(lv), 1'b1, 3'(src), 2'b00});
        for (int a = 0; a < 8; a++) begin
          for (int bi = 0; bi < 33; bi++) begin
            logic [7:0] b;
            b = (bi == 32) ? 8'hFF : (bi < 16) ? 8'(bi) : 8'(bi - 16) << 4;
            @(negedge clk);
            pin_a = 3'(a); pin_b = b; stop_in = 1'b0;
            cyc(3);
            check("R6 stop low", {7'b0, wake_req}, 8'h00);
            stop_in = 1'b1; #0.5;
            check((src < 2) ? "R5 dead code" : "R3 R4 source/level",
                  {7'b0, wake_req},
                  {7'b0, exp_wake(src, 1'(lv), 3'(a), b, 1'b1)});
            @(negedge clk); stop_in = 1'b0;
            cyc(2);
          end
        end
      end
    end

    // R10 cleared only by power-on
    por_n = 1'b0; cyc(2); por_n = 1'b1; cyc(2);
    rd(d); check("R10 por clears flag", d, 8'h7F);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule